// File: doc/BRIEF.md
# Four-phase bus cycle controller sequencer

This block is the control sequencer for a 16-bit load/store processor. Every major step of the processor occupies one bus transfer of four clocks. The block counts the four sub-phases of that transfer in Gray order and drives the active-low bus strobes from the sub-phase. It moves between its three major states, fetch-one, fetch-two and execute, only on the last sub-phase of a transfer. The target state is chosen by the two mode bits that sit in bits 15:14 of the instruction word.

The datapath feeds the mode bits in on `mode_i`. At the data-hold phase of fetch-one the block raises `load_ir_o` for one clock, so that the datapath captures the instruction word at that edge. On every data-hold phase it raises `bus_done_o` for one clock. Register-register instructions take one transfer. Register-immediate instructions take a fetch and an execute. Loads and stores take a fetch, a second fetch for the operand word and an execute. A store drives a write cycle during execute.

Top module: `bus_ctrl_sequencer`

## Requirements
- R1: While `rst_n` is low, the major state is fetch-one (code 0) and the sub-phase is address setup (code 0). `ale_n_o`, `me_n_o`, `oe_n_o` and `rd_wr_n_o` are all high, and `bus_done_o` and `load_ir_o` are low. After release the machine starts from that point.
- R2: The sub-phase `phase_o` advances once per clock in the cyclic order address setup (0), address hold (1), data setup (3), data hold (2), whatever the mode bits are.
- R3: The major state `major_o` keeps its value across every clock edge at which the sub-phase is not data hold (2). Mode changes at those edges have no effect on it.
- R4: From fetch-one (0) at data hold, the next major state is fetch-one for mode 00, execute (1) for mode 01, and fetch-two (3) for mode 10 or 11.
- R5: From fetch-two (3) at data hold, the next major state is execute (1) when mode bit 1 is set, and fetch-one (0) when it is clear.
- R6: From execute (1) at data hold, the next major state is always fetch-one (0), whatever the mode.
- R7: Out of reset, `ale_n_o` is low exactly in the address setup sub-phase.
- R8: Out of reset, `me_n_o` is low in address hold, data setup and data hold, and high in address setup.
- R9: A write cycle is the execute state with mode 11 (store). `rd_wr_n_o` is low exactly in write cycles. `oe_n_o` is low in data setup and data hold of every cycle that is not a write cycle, and high at all other times.
- R10: Out of reset, `bus_done_o` is high exactly in the data-hold sub-phase.
- R11: Out of reset, `load_ir_o` is high exactly in the data-hold sub-phase of fetch-one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode bits 15:14 of the current instruction word |
| major_o | output | 2 | Major state: 0 fetch-one, 1 execute, 3 fetch-two |
| phase_o | output | 2 | Bus sub-phase: 0 addr setup, 1 addr hold, 3 data setup, 2 data hold |
| ale_n_o | output | 1 | Address latch enable, active low |
| me_n_o | output | 1 | Memory enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| rd_wr_n_o | output | 1 | High for read, low for write |
| bus_done_o | output | 1 | One-clock pulse at data hold of every transfer |
| load_ir_o | output | 1 | One-clock pulse at data hold of fetch-one |

## Verification
At the data-hold phase of fetch-one, three things happen in the same clock. The transfer-done pulse fires, the instruction-capture pulse fires, and the major state is chosen from the mode bits now on the bus. A wrong decode of the mode at this edge can therefore line up with a correct-looking strobe pattern. The bench drives a new random mode on every clock, including mid-transfer changes that must be ignored and register-mode codes that appear while in fetch-two. A behavioural model predicts state, sub-phase, every strobe and both pulses each cycle, and any divergence is reported against the requirement it breaks. A reset asserted in the middle of a transfer checks that the strobes return to idle at once.

// File: rtl/bus_ctrl_pkg.sv
package bus_ctrl_pkg;

    localparam int MODE_W  = 2;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        MJ_FETCH1 = 2'd0,
        MJ_EXEC   = 2'd1,
        MJ_FETCH2 = 2'd3
    } major_e;

    typedef enum logic [STATE_W-1:0] {
        PH_ADDR_SETUP = 2'd0,
        PH_ADDR_HOLD  = 2'd1,
        PH_DATA_HOLD  = 2'd2,
        PH_DATA_SETUP = 2'd3
    } phase_e;

    localparam logic [MODE_W-1:0] MODE_REG_REG = 2'b00;
    localparam logic [MODE_W-1:0] MODE_REG_IMM = 2'b01;
    localparam logic [MODE_W-1:0] MODE_LOAD    = 2'b10;
    localparam logic [MODE_W-1:0] MODE_STORE   = 2'b11;

    typedef struct packed {
        logic ale_n;
        logic me_n;
        logic oe_n;
        logic rd_wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ale_n: 1'b1, me_n: 1'b1, oe_n: 1'b1, rd_wr_n: 1'b1};

endpackage

// File: rtl/bus_phase_gray.sv
module bus_phase_gray
    import bus_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o,
    output logic   at_hold_o
);

    typedef struct packed {
        phase_e phase;
    } ph_state_t;

    ph_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_ADDR_SETUP: st_d.phase = PH_ADDR_HOLD;
            PH_ADDR_HOLD:  st_d.phase = PH_DATA_SETUP;
            PH_DATA_SETUP: st_d.phase = PH_DATA_HOLD;
            PH_DATA_HOLD:  st_d.phase = PH_ADDR_SETUP;
            default:       st_d.phase = PH_ADDR_SETUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_ADDR_SETUP};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.phase;
    assign at_hold_o = (st_q.phase == PH_DATA_HOLD);

endmodule

// File: rtl/major_state_fsm.sv
module major_state_fsm
    import bus_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              at_hold_i,
    output major_e            major_o
);

    typedef struct packed {
        major_e major;
    } mj_state_t;

    mj_state_t st_d, st_q;
    major_e    target;

    // Destination chosen at the end of a transfer; held otherwise.
    always_comb begin
        unique case (st_q.major)
            MJ_FETCH1: begin
                if (mode_i == MODE_REG_REG)      target = MJ_FETCH1;
                else if (mode_i == MODE_REG_IMM) target = MJ_EXEC;
                else                             target = MJ_FETCH2;
            end
            MJ_FETCH2: target = mode_i[1] ? MJ_EXEC : MJ_FETCH1;
            MJ_EXEC:   target = MJ_FETCH1;
            default:   target = MJ_FETCH1;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (at_hold_i) begin
            st_d.major = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{major: MJ_FETCH1};
        end else begin
            st_q <= st_d;
        end
    end

    assign major_o = st_q.major;

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_ctrl_pkg::*;
(
    input  logic              active_i,
    input  major_e            major_i,
    input  phase_e            phase_i,
    input  logic [MODE_W-1:0] mode_i,
    output strobe_t           strobe_o,
    output logic              bus_done_o,
    output logic              load_ir_o
);

    logic write_cycle;
    logic data_window;

    always_comb begin
        write_cycle = (major_i == MJ_EXEC) && (mode_i == MODE_STORE);
        data_window = (phase_i == PH_DATA_SETUP) || (phase_i == PH_DATA_HOLD);

        strobe_o   = STROBE_IDLE;
        bus_done_o = 1'b0;
        load_ir_o  = 1'b0;

        if (active_i) begin
            strobe_o.ale_n   = (phase_i != PH_ADDR_SETUP);
            strobe_o.me_n    = (phase_i == PH_ADDR_SETUP);
            strobe_o.oe_n    = !(data_window && !write_cycle);
            strobe_o.rd_wr_n = !write_cycle;
            bus_done_o       = (phase_i == PH_DATA_HOLD);
            load_ir_o        = (phase_i == PH_DATA_HOLD) && (major_i == MJ_FETCH1);
        end
    end

endmodule

// File: rtl/bus_ctrl_sequencer.sv
module bus_ctrl_sequencer
    import bus_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    output logic [STATE_W-1:0] major_o,
    output logic [STATE_W-1:0] phase_o,
    output logic              ale_n_o,
    output logic              me_n_o,
    output logic              oe_n_o,
    output logic              rd_wr_n_o,
    output logic              bus_done_o,
    output logic              load_ir_o
);

    phase_e  phase;
    major_e  major;
    logic    at_hold;
    strobe_t strobe;

    bus_phase_gray u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_o   (phase),
        .at_hold_o (at_hold)
    );

    major_state_fsm u_major (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .at_hold_i (at_hold),
        .major_o   (major)
    );

    bus_strobe_gen u_strobe (
        .active_i   (rst_n),
        .major_i    (major),
        .phase_i    (phase),
        .mode_i     (mode_i),
        .strobe_o   (strobe),
        .bus_done_o (bus_done_o),
        .load_ir_o  (load_ir_o)
    );

    assign major_o   = major;
    assign phase_o   = phase;
    assign ale_n_o   = strobe.ale_n;
    assign me_n_o    = strobe.me_n;
    assign oe_n_o    = strobe.oe_n;
    assign rd_wr_n_o = strobe.rd_wr_n;

endmodule

// File: rtl/bus_ctrl_sequencer_chk.sv
module bus_ctrl_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic [1:0] major_o,
    input logic [1:0] phase_o,
    input logic       ale_n_o,
    input logic       me_n_o,
    input logic       oe_n_o,
    input logic       rd_wr_n_o,
    input logic       bus_done_o,
    input logic       load_ir_o
);

    // R1
    always_comb begin
        if (!rst_n) begin
            idle_in_reset_chk: assert (ale_n_o && me_n_o && oe_n_o && rd_wr_n_o && !bus_done_o && !load_ir_o);
        end
    end

    // R2
    gray_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0) |=> (phase_o == 2'd1));
    // R2
    gray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1) |=> (phase_o == 2'd3));
    // R2
    gray_dsetup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |=> (phase_o == 2'd2));
    // R2
    gray_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2) |=> (phase_o == 2'd0));

    // R3
    major_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd2) |=> $stable(major_o));

    // R6
    exec_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (major_o == 2'd1 && phase_o == 2'd2) |=> (major_o == 2'd0));

    // R5
    fetch2_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (major_o == 2'd3 && phase_o == 2'd2 && mode_i[1]) |=> (major_o == 2'd1));

    // R7
    ale_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_n_o) |-> (phase_o == 2'd0 && me_n_o));

    // R9
    write_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_wr_n_o) |-> (oe_n_o && major_o == 2'd1));

    // R11
    load_ir_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_ir_o |-> (bus_done_o && major_o == 2'd0));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_done_o |=> !bus_done_o);

endmodule

bind bus_ctrl_sequencer bus_ctrl_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .major_o    (major_o),
    .phase_o    (phase_o),
    .ale_n_o    (ale_n_o),
    .me_n_o     (me_n_o),
    .oe_n_o     (oe_n_o),
    .rd_wr_n_o  (rd_wr_n_o),
    .bus_done_o (bus_done_o),
    .load_ir_o  (load_ir_o)
);

// File: tb/bus_ctrl_sequencer_tb_top.sv
module bus_ctrl_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;

    logic [1:0] major_o, phase_o;
    logic       ale_n_o, me_n_o, oe_n_o, rd_wr_n_o, bus_done_o, load_ir_o;

    int compared = 0;
    int mismatched = 0;

    // reference state
    int m_major = 0;
    int m_phase = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_ctrl_sequencer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .major_o    (major_o),
        .phase_o    (phase_o),
        .ale_n_o    (ale_n_o),
        .me_n_o     (me_n_o),
        .oe_n_o     (oe_n_o),
        .rd_wr_n_o  (rd_wr_n_o),
        .bus_done_o (bus_done_o),
        .load_ir_o  (load_ir_o)
    );

    task automatic cmp(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        bit wr;
        int e_ale, e_me, e_oe, e_rw, e_done, e_ir;
        if (!rst_n) begin
            cmp("R1", "major", int'(major_o), 0);
            cmp("R1", "phase", int'(phase_o), 0);
            cmp("R1", "ale_n", int'(ale_n_o), 1);
            cmp("R1", "me_n", int'(me_n_o), 1);
            cmp("R1", "oe_n", int'(oe_n_o), 1);
            cmp("R1", "rd_wr_n", int'(rd_wr_n_o), 1);
            cmp("R1", "bus_done", int'(bus_done_o), 0);
            cmp("R1", "load_ir", int'(load_ir_o), 0);
            return;
        end
        wr     = (m_major == 1) && (mode == 2'b11);
        e_ale  = (m_phase == 0) ? 0 : 1;
        e_me   = (m_phase == 0) ? 1 : 0;
        e_oe   = ((m_phase == 3 || m_phase == 2) && !wr) ? 0 : 1;
        e_rw   = wr ? 0 : 1;
        e_done = (m_phase == 2) ? 1 : 0;
        e_ir   = (m_phase == 2 && m_major == 0) ? 1 : 0;
        cmp("R3/R4/R5/R6", "major", int'(major_o), m_major);
        cmp("R2", "phase", int'(phase_o), m_phase);
        cmp("R7", "ale_n", int'(ale_n_o), e_ale);
        cmp("R8", "me_n", int'(me_n_o), e_me);
        cmp("R9", "oe_n", int'(oe_n_o), e_oe);
        cmp("R9", "rd_wr_n", int'(rd_wr_n_o), e_rw);
        cmp("R10", "bus_done", int'(bus_done_o), e_done);
        cmp("R11", "load_ir", int'(load_ir_o), e_ir);
    endtask

    // Advance the model to the state after the coming rising edge.
    task automatic model_step();
        int nm;
        if (!rst_n) begin
            m_major = 0;
            m_phase = 0;
            return;
        end
        nm = m_major;
        if (m_phase == 2) begin
            case (m_major)
                0: nm = (mode == 2'b00) ? 0 : (mode == 2'b01) ? 1 : 3;
                3: nm = mode[1] ? 1 : 0;
                default: nm = 0;
            endcase
        end
        case (m_phase)
            0: m_phase = 1;
            1: m_phase = 3;
            3: m_phase = 2;
            default: m_phase = 0;
        endcase
        m_major = nm;
    endtask

    task automatic cycle(input logic [1:0] m);
        @(negedge clk);
        check_outputs();
        mode = m;
        model_step();
    endtask

    initial begin
        // R1: reset held for a few cycles
        repeat (3) cycle(2'b00);
        @(negedge clk);
        check_outputs();
        rst_n = 1'b1;
        model_step();

        // R4 mode 00 stays in fetch-one
        repeat (24) cycle(2'b00);
        // R4 mode 01 alternates fetch-one / execute (R6)
        repeat (24) cycle(2'b01);
        // R4/R5 loads
        repeat (36) cycle(2'b10);
        // R9 stores produce write cycles
        repeat (36) cycle(2'b11);

        // R1: reset in the middle of a transfer
        repeat (2) cycle(2'b11);
        @(negedge clk);
        check_outputs();
        rst_n = 1'b0;
        #1;
        m_major = 0;
        m_phase = 0;
        repeat (2) cycle(2'b10);
        @(negedge clk);
        check_outputs();
        rst_n = 1'b1;
        model_step();

        // R3/R5: mode changes every clock, including register modes seen in fetch-two
        for (int i = 0; i < 2000; i++) begin
            cycle(2'($urandom_range(0, 3)));
        end

        @(negedge clk);
        check_outputs();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired after %0d cycles", WATCHDOG_CYCLES);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule